// File: doc/BRIEF.md
# Toggle-Flag Word Crossing Between Clock Domains

This block carries a wide data word from a fast clock domain into a slower clock domain that has no fixed phase relation to it. On the fast side, an accepted write stores the word in a holding register and inverts a single event flag. The holding register then stays frozen for a fixed spacing window, and a busy output blocks further writes during that window.

On the slow side, the flag passes through a two-flop synchroniser. It is then compared with a one-cycle-delayed copy of itself. A mismatch arms a capture for the following slow cycle. On that cycle the whole frozen word is loaded into the output register, and a one-cycle valid pulse is raised. Because the load happens one cycle after the change is detected, the wide capture never races the flag across a clock edge.

No acknowledge travels back to the fast side. The spacing window alone guarantees that the flag never toggles twice within one slow period. It also guarantees that the word is still steady when the slow side samples it.

Top module: `toggle_bus_cdc`

## Requirements
- R1: While both resets are low and right after their release, `busy` is 0, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: Every write accepted on the fast side is delivered exactly once on `rd_data`, with `rd_valid` high, bit for bit and in acceptance order. This includes the all-zeros and all-ones words. A write is accepted when `wr_en` is 1 at a rising `fast_clk` edge while `busy` is 0.
- R3: `rd_valid` is high for a single slow cycle per delivered word. `rd_data` keeps its value on every slow cycle where `rd_valid` is 0.
- R4: After an accepted write, `busy` is 1 for exactly SPACING-1 fast cycles and then returns to 0. SPACING defaults to 24.
- R5: `wr_en` asserted while `busy` is 1 is ignored. No extra word is delivered, and the word that is delivered is the earlier accepted one.
- R6: `rd_valid` rises on the fourth rising `slow_clk` edge after the fast edge that accepted the write. That edge count covers two synchroniser stages, one edge-detect stage and one capture stage.
- R7: With `wr_en` held high continuously, a new word is accepted every SPACING fast cycles, and every accepted word is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Source-domain clock |
| fast_rst_n | input | 1 | Source-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; the word is taken when busy is 0 |
| wr_data | input | DATA_W | Word to transfer |
| busy | output | 1 | High while the spacing window blocks a new write |
| slow_clk | input | 1 | Destination-domain clock |
| slow_rst_n | input | 1 | Destination-domain asynchronous reset, active low |
| rd_data | output | DATA_W | Last captured word |
| rd_valid | output | 1 | One-cycle pulse when a new word appears on rd_data |

## Verification
The inline properties check four things on every cycle:
- The holding register and the flag stay frozen while busy is high.
- Busy follows every accepted write.
- The valid pulse lasts a single cycle.
- The output word changes only together with a valid pulse.

Only the bench's scenarios can show the rest: end-to-end delivery of each word in order, the exact four-edge latency counted in slow edges, and rejection of writes that arrive while busy is high. Continuous back-to-back streaming at the spacing limit is likewise covered only by the bench.

// File: rtl/tcdc_pkg.sv
package tcdc_pkg;
    // Number of flops the event flag passes before edge detection.
    localparam int SYNC_STAGES = 2;

    // Width needed to hold a count from 0 to n-1, at least one bit.
    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tcdc_sync.sv
module tcdc_sync #(
    parameter int STAGES = tcdc_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcdc_src.sv
module tcdc_src #(
    parameter int DATA_W  = 108,
    parameter int SPACING = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic [DATA_W-1:0] word_o,
    output logic              flag_o
);
    localparam int CW = tcdc_pkg::cnt_bits(SPACING);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              flag;
        logic [CW-1:0]     gap;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = wr_en && (st_q.gap == '0);
        if (take) begin
            st_d.word = wr_data;
            st_d.flag = ~st_q.flag;
            st_d.gap  = CW'(SPACING - 1);
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = (st_q.gap != '0);
    assign word_o = st_q.word;
    assign flag_o = st_q.flag;

    // R5
    busy_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(flag_o));

    // R5
    busy_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_o));

    // R4
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> (busy && (flag_o != $past(flag_o))));
endmodule

// File: rtl/tcdc_dst.sv
module tcdc_dst #(
    parameter int DATA_W = 108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_async,
    input  logic [DATA_W-1:0] word_async,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic              prev;
        logic              pend;
        logic              valid;
        logic [DATA_W-1:0] data;
    } dst_st_t;

    dst_st_t st_d, st_q;
    logic    flag_sync;

    tcdc_sync #(.STAGES(tcdc_pkg::SYNC_STAGES)) flag_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(flag_async),
        .sync_o (flag_sync)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prev  = flag_sync;
        st_d.pend  = flag_sync ^ st_q.prev;
        st_d.valid = st_q.pend;
        if (st_q.pend) st_d.data = word_async;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

    // R3
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R3
    data_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> $stable(rd_data));
endmodule

// File: rtl/toggle_bus_cdc.sv
module toggle_bus_cdc #(
    parameter int DATA_W  = 108,
    parameter int SPACING = 24
) (
    input  logic              fast_clk,
    input  logic              fast_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] frozen_word;
    logic              event_flag;

    tcdc_src #(.DATA_W(DATA_W), .SPACING(SPACING)) src_i (
        .clk    (fast_clk),
        .rst_n  (fast_rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .busy   (busy),
        .word_o (frozen_word),
        .flag_o (event_flag)
    );

    tcdc_dst #(.DATA_W(DATA_W)) dst_i (
        .clk       (slow_clk),
        .rst_n     (slow_rst_n),
        .flag_async(event_flag),
        .word_async(frozen_word),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: tb/toggle_bus_cdc_tb_top.sv
`timescale 1ns/100ps
module toggle_bus_cdc_tb_top;
    localparam int W = 108;
    localparam int SP = 24;

    logic fast_clk = 0, slow_clk = 0;
    logic fast_rst_n = 0, slow_rst_n = 0;
    logic wr_en = 0;
    logic [W-1:0] wr_data = '0;
    logic busy, rd_valid;
    logic [W-1:0] rd_data;

    int checks = 0, failures = 0;
    int slow_edges = 0, delivered = 0, rem = 0;
    logic prev_valid = 0;
    logic [W-1:0] last_data = '0;
    logic [W-1:0] exp_q[$];
    int at_q[$];

    always #4 fast_clk = ~fast_clk;
    always #17.5 slow_clk = ~slow_clk;

    toggle_bus_cdc #(.DATA_W(W), .SPACING(SP)) dut_i (
        .fast_clk(fast_clk), .fast_rst_n(fast_rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .busy(busy), .slow_clk(slow_clk),
        .slow_rst_n(slow_rst_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [W-1:0] mk(input int k);
        return {32'(k) * 32'h9E37_79B9, ~32'(k), 32'(k) ^ 32'h5A5A_A5A5, 12'(k)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge slow_clk) slow_edges++;

    // Reference model of acceptance: a write is taken when the spacing window is over.
    always @(posedge fast_clk) begin
        if (!fast_rst_n) rem <= 0;
        else if (wr_en && rem == 0) begin
            rem <= SP - 1;
            exp_q.push_back(wr_data);
            at_q.push_back(slow_edges);
        end else if (rem != 0) rem <= rem - 1;
    end

    // Monitor: pops the expected word and its edge stamp on each valid pulse.
    always @(negedge slow_clk) begin
        if (slow_rst_n) begin
            if (rd_valid) begin
                check(!prev_valid, "R3 valid pulse width", W'(prev_valid), '0);
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected word", rd_data, '0);
                end else begin
                    logic [W-1:0] e;
                    int a;
                    e = exp_q.pop_front();
                    a = at_q.pop_front();
                    check(rd_data == e, "R2 delivered word", rd_data, e);
                    check(slow_edges - a == 4, "R6 latency in slow edges",
                          W'(slow_edges - a), W'(4));
                end
                last_data = rd_data;
                delivered++;
            end else begin
                check(rd_data == last_data, "R3 rd_data hold", rd_data, last_data);
            end
            prev_valid = rd_valid;
        end
    end

    task automatic do_write(input logic [W-1:0] v);
        @(negedge fast_clk);
        wr_en = 1; wr_data = v;
        @(negedge fast_clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge fast_clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int base;
        idle(5);
        check(busy == 0, "R1 busy in reset", W'(busy), '0);
        check(rd_valid == 0, "R1 rd_valid in reset", W'(rd_valid), '0);
        check(rd_data == '0, "R1 rd_data in reset", rd_data, '0);
        fast_rst_n = 1; slow_rst_n = 1;
        idle(3);
        check(busy == 0 && rd_valid == 0 && rd_data == '0, "R1 after release",
              {rd_data[W-1:2], busy, rd_valid}, '0);

        // R2: distinct patterns, including all ones and all zeros
        do_write({W{1'b1}}); idle(SP + 4);
        do_write('0);        idle(SP + 4);
        do_write({27{4'hA}}); idle(SP + 4);
        do_write(mk(7));     idle(SP + 4);

        // R4: busy window length
        do_write(mk(11));
        for (int i = 1; i <= SP; i++) begin
            if (i > 1) @(negedge fast_clk);
            check(busy == (i < SP), "R4 busy window", W'(busy), W'(i < SP));
        end
        idle(SP);

        // R5: writes during busy are ignored
        base = delivered;
        do_write(mk(21));
        for (int i = 1; i < SP; i++) begin
            wr_en = 1; wr_data = mk(1000 + i);
            @(negedge fast_clk);
        end
        wr_en = 0;
        idle(3 * SP);
        check(delivered == base + 1, "R5 count after busy writes",
              W'(delivered), W'(base + 1));
        check(last_data == mk(21), "R5 word kept", last_data, mk(21));

        // R7: continuous strobe, one word per SPACING cycles
        base = delivered;
        @(negedge fast_clk);
        for (int i = 0; i < 4 * SP; i++) begin
            wr_en = 1; wr_data = mk(200 + i);
            @(negedge fast_clk);
        end
        wr_en = 0;
        idle(3 * SP);
        check(delivered == base + 4, "R7 streamed words", W'(delivered), W'(base + 4));
        check(last_data == mk(200 + 3 * SP), "R7 last streamed word",
              last_data, mk(200 + 3 * SP));
        check(exp_q.size() == 0, "R2 nothing outstanding", W'(exp_q.size()), '0);
        finish_run();
    end
endmodule